// File: doc/BRIEF.md
# DS1 Idle Code Generator

This block produces a serial DS1-rate idle signal for substitution onto any of 24 tributary channels. It offers three idle patterns: a zero-suppressed quasi-random sequence, a framed extended-superframe signal that carries all ones, and an unframed all-ones alarm signal. One pattern is active at a time, and every substituted channel carries that same pattern.

The generator advances one bit on each clock where the shared DS1 bit-rate enable `tick_i` is high. The current idle bit is always present on `idle_bit_o`. The extended-superframe position counter runs in every mode, so its superframe boundary is the only point at which a new pattern selection is adopted. A registered 24-bit channel mask reports which channels take the idle bit. A channel is in that mask when its enable bit is set and its loopback bit is clear.

Top module: `ds1_idle_gen`

## Requirements
- R1: `sel_i` picks the pattern. `sel_i[0]=0` gives the quasi-random signal whatever `sel_i[1]` is. `sel_i=2'b01` gives the framed all-ones superframe signal. `sel_i=2'b11` gives the unframed all-ones signal.
- R2: The quasi-random raw sequence obeys r[n+20] = r[n] XOR r[n+3] (polynomial x^20+x^17+1). Its first 20 raw bits after reset are ones. Each output bit is forced to one when that raw bit and the 13 raw bits after it are all zero.
- R3: The quasi-random output never holds 14 or more consecutive zeros.
- R4: Superframe mode uses 193-bit frames, each starting with one framing bit, with 24 frames per superframe. Every one of the 192 payload bits is one.
- R5: The framing bits of frames 4, 8, 12, 16, 20 and 24 carry 0, 0, 1, 0, 1, 1 in that order.
- R6: The framing bits of frames 2, 6, 10, 14, 18 and 22 carry a CRC-6, most significant bit first. The CRC is the remainder of M(x)·x^6 modulo x^6+x+1. M is the previous superframe's 4632 bits, first bit highest, with framing bits taken as ones. All other framing bits are ones.
- R7: In unframed alarm mode every output bit is one.
- R8: A new `sel_i` value is sampled only on the tick of the last bit of frame 24. It takes effect from frame 1, bit 0. A change at any other point has no effect until then.
- R9: One clock after the inputs are applied, `subst_o[i]` equals `idle_en_i[i] & ~lpbk_i[i]`, so a set loopback bit always wins. `subst_o` is zero in reset.
- R10: The pattern state does not advance on clocks where `tick_i` is low.
- R11: Reset puts the LFSR in the all-ones state, selects the quasi-random pattern and sets the position to frame 1, bit 0. The first output bit after reset is therefore one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | DS1 bit-rate enable; one idle bit consumed per high cycle |
| sel_i | input | 2 | Idle pattern select (R1 encoding) |
| idle_en_i | input | 24 | Per-channel idle substitution enable |
| lpbk_i | input | 24 | Per-channel loopback; overrides the enable |
| idle_bit_o | output | 1 | Current idle bit, shared by all substituted channels |
| subst_o | output | 24 | Registered mask of channels carrying the idle bit |

## Verification
A corrupted LFSR state produces a mismatch against the recurrence within 20 ticks. An unreachable all-zero state shows within one tick as a constant one, since suppression then forces every bit high. A slipped frame or bit counter shifts framing bits into payload positions. It appears as a zero at a payload position, or a misplaced 001011 bit, within one 193-bit frame. A wrong CRC accumulator, or a CRC slot that sends bits in the wrong order, is visible at frame 2 of the next superframe, at most 4632 ticks later. A mode register that updates off the boundary changes the output pattern in the middle of a superframe. Mask faults show one clock after the inputs change.

// File: rtl/ds1_idle_pkg.sv
`timescale 1ns/1ps
package ds1_idle_pkg;

  typedef enum logic [1:0] {
    MODE_QRS = 2'd0,
    MODE_ESF = 2'd1,
    MODE_AIS = 2'd2
  } idle_mode_e;

  // bit 0 low: quasi-random; 01: framed ones; 11: unframed ones
  function automatic idle_mode_e decode_sel(input logic [1:0] sel);
    if (!sel[0])      return MODE_QRS;
    else if (!sel[1]) return MODE_ESF;
    else              return MODE_AIS;
  endfunction

endpackage

// File: rtl/ds1_qrs_gen.sv
`timescale 1ns/1ps
module ds1_qrs_gen #(
  parameter int LFSR_W = 20,
  parameter int TAP    = 17,
  parameter int ZMAX   = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic qrs_o
);

  localparam int ZCNT_W = $clog2(ZMAX + 1) + 1;

  logic [LFSR_W-1:0] lfsr_q;
  logic              fb;

  assign fb    = lfsr_q[LFSR_W-1] ^ lfsr_q[TAP-1];
  // window of the current raw bit and the following ZMAX-1 raw bits
  assign qrs_o = lfsr_q[LFSR_W-1] | ~(|lfsr_q[LFSR_W-1 -: ZMAX]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lfsr_q <= '1;
    else if (tick_i) lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
  end

  // run-length monitor for the zero-suppression guarantee
  logic [ZCNT_W-1:0] zrun_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zrun_q <= '0;
    else if (tick_i) begin
      if (qrs_o) zrun_q <= '0;
      else if (zrun_q != {ZCNT_W{1'b1}}) zrun_q <= zrun_q + 1'b1;
    end
  end

  a_r3_zero_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zrun_q < ZCNT_W'(ZMAX));

  a_r2_lfsr_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(lfsr_q));

endmodule

// File: rtl/ds1_esf_gen.sv
`timescale 1ns/1ps
module ds1_esf_gen #(
  parameter int              FRAME_BITS = 193,
  parameter int              FRAMES     = 24,
  parameter int              CRC_W      = 6,
  parameter logic [CRC_W-1:0] CRC_POLY  = 6'h03,
  parameter logic [CRC_W-1:0] FPS_PAT   = 6'b001011
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic esf_o,
  output logic sf_end_o
);

  localparam int BIT_W  = $clog2(FRAME_BITS);
  localparam int FR_W   = $clog2(FRAMES);
  localparam int SLOT_W = FR_W - 2;
  localparam int NSLOT  = FRAMES / 4;

  logic [BIT_W-1:0]  bit_q;
  logic [FR_W-1:0]   frame_q;
  logic [CRC_W-1:0]  crc_acc_q, crc_tx_q, crc_nxt;
  logic              last_bit, crc_din, fps_bit, crc_bit, framing;
  logic [SLOT_W-1:0] slot;

  assign last_bit = (bit_q == BIT_W'(FRAME_BITS - 1));
  assign sf_end_o = last_bit && (frame_q == FR_W'(FRAMES - 1));
  assign slot     = frame_q[FR_W-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= '0;
      frame_q <= '0;
    end else if (tick_i) begin
      if (last_bit) begin
        bit_q   <= '0;
        frame_q <= sf_end_o ? '0 : frame_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  // payload is all ones; framing positions count as ones for the CRC
  localparam logic PAYLOAD = 1'b1;
  assign crc_din = (bit_q == '0) | PAYLOAD;
  assign crc_nxt = {crc_acc_q[CRC_W-2:0], 1'b0}
                 ^ ((crc_din ^ crc_acc_q[CRC_W-1]) ? CRC_POLY : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_acc_q <= '0;
      crc_tx_q  <= '0;
    end else if (tick_i) begin
      if (sf_end_o) begin
        crc_tx_q  <= crc_nxt;
        crc_acc_q <= '0;
      end else begin
        crc_acc_q <= crc_nxt;
      end
    end
  end

  always_comb begin
    fps_bit = 1'b1;
    crc_bit = 1'b1;
    for (int k = 0; k < NSLOT; k++) begin
      if (slot == SLOT_W'(k)) begin
        fps_bit = FPS_PAT[NSLOT-1-k];
        crc_bit = crc_tx_q[CRC_W-1-k];
      end
    end
  end

  always_comb begin
    unique case (frame_q[1:0])
      2'b11:   framing = fps_bit;
      2'b01:   framing = crc_bit;
      default: framing = 1'b1;
    endcase
  end

  assign esf_o = (bit_q == '0) ? framing : PAYLOAD;

  a_r4_bit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q < BIT_W'(FRAME_BITS) && frame_q < FR_W'(FRAMES));

  a_r4_payload_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_q != '0) |-> esf_o);

  a_r5_first_fps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_q == '0 && frame_q == FR_W'(3)) |-> !esf_o);

  a_r4_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !last_bit) |=> bit_q == $past(bit_q) + 1'b1);

  a_r6_crc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && sf_end_o) |=> $stable(crc_tx_q));

endmodule

// File: rtl/ds1_chan_mask.sv
`timescale 1ns/1ps
module ds1_chan_mask #(
  parameter int NUM_CH = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] idle_en_i,
  input  logic [NUM_CH-1:0] lpbk_i,
  output logic [NUM_CH-1:0] subst_o
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) subst_o[ch] <= 1'b0;
      else         subst_o[ch] <= idle_en_i[ch] && !lpbk_i[ch];
    end
  end

  a_r9_lpbk_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (subst_o & $past(lpbk_i)) == '0);

  a_r9_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (subst_o & ~$past(idle_en_i)) == '0);

endmodule

// File: rtl/ds1_idle_gen.sv
`timescale 1ns/1ps
module ds1_idle_gen
  import ds1_idle_pkg::*;
#(
  parameter int NUM_CH     = 24,
  parameter int FRAME_BITS = 193,
  parameter int FRAMES     = 24,
  parameter int LFSR_W     = 20,
  parameter int LFSR_TAP   = 17,
  parameter int ZMAX       = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        sel_i,
  input  logic [NUM_CH-1:0] idle_en_i,
  input  logic [NUM_CH-1:0] lpbk_i,
  output logic              idle_bit_o,
  output logic [NUM_CH-1:0] subst_o
);

  idle_mode_e mode_q;
  logic       qrs_bit, esf_bit, sf_end;

  ds1_qrs_gen #(.LFSR_W(LFSR_W), .TAP(LFSR_TAP), .ZMAX(ZMAX)) i_qrs (
    .clk_i, .rst_ni, .tick_i, .qrs_o(qrs_bit)
  );

  ds1_esf_gen #(.FRAME_BITS(FRAME_BITS), .FRAMES(FRAMES)) i_esf (
    .clk_i, .rst_ni, .tick_i, .esf_o(esf_bit), .sf_end_o(sf_end)
  );

  ds1_chan_mask #(.NUM_CH(NUM_CH)) i_mask (
    .clk_i, .rst_ni, .idle_en_i, .lpbk_i, .subst_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mode_q <= MODE_QRS;
    else if (tick_i && sf_end)  mode_q <= decode_sel(sel_i);
  end

  always_comb begin
    unique case (mode_q)
      MODE_ESF: idle_bit_o = esf_bit;
      MODE_AIS: idle_bit_o = 1'b1;
      default:  idle_bit_o = qrs_bit;
    endcase
  end

  a_r8_mode_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> $past(tick_i && sf_end));

  a_r7_ais_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_AIS) |-> idle_bit_o);

  a_r1_legal_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != idle_mode_e'(2'd3));

endmodule

// File: tb/test_ds1_idle_gen.sv
`timescale 1ns/1ps
module test_ds1_idle_gen;

  localparam int NCH   = 24;
  localparam int SFB   = 193 * 24;
  localparam int NMASK = 6;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           tick_i = 1'b0;
  logic [1:0]     sel_i = 2'b00;
  logic [NCH-1:0] idle_en_i = '1;
  logic [NCH-1:0] lpbk_i = '0;
  logic           idle_bit_o;
  logic [NCH-1:0] subst_o;

  always #4 clk = ~clk;

  ds1_idle_gen i_ds1_idle_gen (
    .clk_i(clk), .rst_ni, .tick_i, .sel_i, .idle_en_i, .lpbk_i,
    .idle_bit_o, .subst_o
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {enable, loopback, expected subst}
  localparam logic [3*NCH-1:0] MASK_VEC [NMASK] = '{
    {24'hFFFFFF, 24'h000000, 24'hFFFFFF},
    {24'hFFFFFF, 24'hFFFFFF, 24'h000000},
    {24'h000000, 24'hFFFFFF, 24'h000000},
    {24'hA5A5A5, 24'h0F0F0F, 24'hA0A0A0},
    {24'h800001, 24'h000001, 24'h800000},
    {24'h123456, 24'h000000, 24'h123456}
  };

  // reference model state
  logic [19:0] lfsr_m = '1;
  int          fr_m = 0, bit_m = 0, mode_m = 0;
  logic [5:0]  crc_ref;
  localparam logic [5:0] FPS = 6'b001011;

  int mm_qrs = 0, mm_fps = 0, mm_crc = 0, mm_pay = 0, mm_ais = 0, mm_bnd = 0;
  int zrun = 0, zmax = 0, n_tick = 0;
  int n_esf = 0, n_ais = 0, n_qrs = 0;
  int last_switch = -1000;

  function automatic int dec(input logic [1:0] s);
    if (!s[0]) return 0;
    if (!s[1]) return 1;
    return 2;
  endfunction

  task automatic step_cmp();
    logic e;
    @(negedge clk);
    case (mode_m)
      1: begin
        n_esf++;
        if (bit_m != 0) e = 1'b1;
        else if (fr_m % 4 == 3) e = FPS[5 - fr_m / 4];
        else if (fr_m % 4 == 1) e = crc_ref[5 - fr_m / 4];
        else e = 1'b1;
      end
      2: begin n_ais++; e = 1'b1; end
      default: begin n_qrs++; e = lfsr_m[19] | (lfsr_m[19:6] == '0); end
    endcase
    if (idle_bit_o !== e) begin
      if (n_tick - last_switch < 60) mm_bnd++;
      case (mode_m)
        1: if (bit_m != 0) mm_pay++;
           else if (fr_m % 4 == 1) mm_crc++;
           else mm_fps++;
        2: mm_ais++;
        default: mm_qrs++;
      endcase
    end
    if (mode_m == 0) begin
      if (idle_bit_o === 1'b0) begin
        zrun++;
        if (zrun > zmax) zmax = zrun;
      end else zrun = 0;
    end else zrun = 0;
    lfsr_m = {lfsr_m[18:0], lfsr_m[19] ^ lfsr_m[16]};
    if (bit_m == 192) begin
      bit_m = 0;
      if (fr_m == 23) begin
        fr_m = 0;
        if (dec(sel_i) != mode_m) last_switch = n_tick + 1;
        mode_m = dec(sel_i);
      end else fr_m++;
    end else bit_m++;
    n_tick++;
    tick_i = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    crc_ref = '0;
    for (int i = 0; i < SFB; i++)
      crc_ref = {crc_ref[4:0], 1'b0} ^ ((1'b1 ^ crc_ref[5]) ? 6'h03 : 6'h00);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(subst_o == '0, "R9 reset mask", int'(subst_o), 0);
    chk(idle_bit_o == 1'b1, "R11 first bit", int'(idle_bit_o), 1);
    rst_ni = 1'b1;

    for (int v = 0; v < NMASK; v++) begin
      @(negedge clk);
      idle_en_i = MASK_VEC[v][3*NCH-1 -: NCH];
      lpbk_i    = MASK_VEC[v][2*NCH-1 -: NCH];
      @(posedge clk);
      @(negedge clk);
      chk(subst_o == MASK_VEC[v][NCH-1:0], "R9 mask vector",
          int'(subst_o), int'(MASK_VEC[v][NCH-1:0]));
    end

    // no ticks so far: still at the reset position
    chk(idle_bit_o == 1'b1, "R10 no advance without tick", int'(idle_bit_o), 1);

    for (int n = 0; n < 17 * SFB; n++) begin
      if (n == 12 * SFB - 50) sel_i = 2'b01;
      if (n == 12 * SFB + 40) sel_i = 2'b11;   // mid-superframe: must wait
      if (n == 13 * SFB - 50) sel_i = 2'b01;
      if (n == 15 * SFB - 50) sel_i = 2'b11;
      if (n == 16 * SFB - 50) sel_i = 2'b10;
      step_cmp();
    end
    @(negedge clk);
    tick_i = 1'b0;

    chk(mm_qrs == 0, "R2 QRS stream mismatches", mm_qrs, 0);
    chk(zmax < 14, "R3 longest zero run", zmax, 13);
    chk(mm_pay == 0, "R4 payload mismatches", mm_pay, 0);
    chk(mm_fps == 0, "R5 FPS mismatches", mm_fps, 0);
    chk(mm_crc == 0, "R6 CRC mismatches", mm_crc, 0);
    chk(mm_ais == 0 && n_ais == SFB, "R7 AIS mismatches", mm_ais, 0);
    chk(mm_bnd == 0, "R8 boundary mismatches", mm_bnd, 0);
    chk(n_esf == 3 * SFB && n_qrs == 13 * SFB, "R1 mode occupancy", n_esf, 3 * SFB);
    chk(mm_qrs + mm_pay + mm_fps + mm_crc + mm_ais == 0, "R1 total mismatches",
        mm_qrs + mm_pay + mm_fps + mm_crc + mm_ais, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule